// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs the external bus cycles of a 16-bit processor core whose system bus has a single master. One set of sixteen pins carries the low address and then the data of each cycle. Four more pins carry the top address bits and then a status nibble. An internal requester presents a 20-bit address, write data, a read/write flag, a memory/port flag, an upper-byte flag and a 4-bit status code. The block then runs a four-state cycle (T1 to T4) on the pins. It stretches the cycle while the ready input is low, and it returns read data with a one-cycle done pulse. Between cycles it can hand the whole bus to an external master that raises a hold request.

Bus drivers are described as a value plus an output-enable, so that a pad ring or a wrapper can build the tri-state pins. `ad_oe` covers the sixteen shared address/data lines. `ctl_oe` covers the strobes, the upper address/status lines, the byte-high line, `mio` and `dtr`.

The state machine has seven states. IDLE moves to HOLD when `hold` is high, moves to T1 when a request is valid, and otherwise stays. T1 moves to T2, and T2 moves to T3. T3 moves to T4 when `ready` is high and to TW when it is low. TW stays in TW while `ready` is low and moves to T4 when it is high. T4 always returns to IDLE. HOLD stays while `hold` is high and returns to IDLE when it is low. A synchronous reset forces IDLE from any state.

Top module: `mux_bus_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `rd_n`, `wr_n` and `den_n` high, and `ale`, `hlda` and `done` low. No bus cycle starts while `rst` is high. A request held through reset starts, with `ale` high, in the first cycle after `rst` is sampled low.
- R2: In T1, the cycle after a request is accepted in IDLE, `ale` is high for exactly one cycle. In that cycle `ad_out` equals addr[15:0], `ahs_out` equals addr[19:16], `bhe_n` equals the inverse of the upper-byte flag, and both `ad_oe` and `ctl_oe` are 1.
- R3: From T2 through T4, `ahs_out` carries the request's 4-bit status code and `bhe_n` carries status bit 7, which is always 0.
- R4: In a read, `rd_n` is low in T2, in T3 and in every wait state, and `ad_oe` is 0 from T2 through T4. The value on `ad_in` at the last rising edge with `rd_n` low appears on `rd_data` in T4.
- R5: In a write, `wr_n` is low over the same span as `rd_n` in a read, and `ad_out` equals the write data with `ad_oe` = 1 from T2 through T4. `rd_n` and `wr_n` are never low together.
- R6: From T1 through T4, `mio` is 1 for a memory access and 0 for a port access. `dtr` is 1 for a write and 0 for a read.
- R7: `den_n` is low whenever a strobe is low. In a write it also stays low in T4.
- R8: `ready` is sampled only at the end of T3 and at the end of each wait state. Each low sample adds one wait cycle, so a strobe lasts 2 + (number of low samples) cycles. `ready` during T2 has no effect.
- R9: `done` is high for exactly one cycle, in T4, and both strobes are already high in that cycle.
- R10: `hold` is acted on only in IDLE, where it wins over a pending request. `hlda` rises in the cycle after IDLE. While `hlda` is high, `ctl_oe` and `ad_oe` are 0 and no `ale` is issued.
- R11: When `hold` is sampled low in HOLD, `hlda` falls in the next cycle, `ctl_oe` returns to 1, and a pending request then starts T1 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present; accepted in IDLE when hold is low |
| req_addr | input | 20 | Cycle address |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = port space |
| req_upper | input | 1 | 1 = upper data byte takes part |
| req_status | input | 4 | Status code shown on the upper lines after T1 |
| done | output | 1 | One-cycle completion pulse in T4 |
| rd_data | output | 16 | Captured read data |
| ad_out | output | 16 | Shared address/data lines, driven value |
| ad_oe | output | 1 | Output enable for ad_out |
| ad_in | input | 16 | Shared address/data lines, received value |
| ahs_out | output | 4 | Upper address bits in T1, then status |
| bhe_n | output | 1 | Byte-high enable (active low) in T1, then status bit 7 |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| mio | output | 1 | 1 = memory, 0 = port |
| den_n | output | 1 | Data buffer enable, active low |
| dtr | output | 1 | Buffer direction, 1 = transmit |
| ctl_oe | output | 1 | Output enable for control, upper-line and byte-high outputs |
| ready | input | 1 | Peripheral ready; low inserts wait states |
| hold | input | 1 | Bus request from an external master |
| hlda | output | 1 | Bus grant to the external master |

## Verification
A hold request and a pending processor request can both be present at once. This happens in two places: in the middle of a cycle and in IDLE. The bench raises `hold` in T1 of a read and keeps `req_valid` high. It then checks that `hlda` stays low through T4 and the following IDLE, and that HOLD wins over the request with no `ale`. After `hold` drops, it checks that the waiting request starts one cycle after `hlda` falls. A second overlap joins a reset with a stretched cycle and a request held through the reset: no cycle may start until the reset is sampled low.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_T1   = 3'd1,
        S_T2   = 3'd2,
        S_T3   = 3'd3,
        S_TW   = 3'd4,
        S_T4   = 3'd5,
        S_HOLD = 3'd6
    } bus_state_t;

endpackage

// File: rtl/mbs_fsm.sv
module mbs_fsm
    import mbs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic hold,
    input  logic ready,
    input  logic cyc_write,
    output logic accept,
    output logic cap_rd,
    output logic in_t1,
    output logic data_ph,
    output logic in_cyc,
    output logic ale,
    output logic rd_n,
    output logic wr_n,
    output logic den_n,
    output logic done,
    output logic hlda,
    output logic ctl_oe
);

    bus_state_t state, nxt;
    logic strobe_ph;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (hold)           nxt = S_HOLD;
                else if (req_valid) nxt = S_T1;
                else                nxt = S_IDLE;
            end
            S_T1:   nxt = S_T2;
            S_T2:   nxt = S_T3;
            S_T3:   nxt = ready ? S_T4 : S_TW;
            S_TW:   nxt = ready ? S_T4 : S_TW;
            S_T4:   nxt = S_IDLE;
            S_HOLD: nxt = hold ? S_HOLD : S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        in_t1     = (state == S_T1);
        strobe_ph = (state == S_T2) || (state == S_T3) || (state == S_TW);
        data_ph   = strobe_ph || (state == S_T4);
        in_cyc    = in_t1 || data_ph;
        accept    = !rst && (state == S_IDLE) && !hold && req_valid;
        cap_rd    = ((state == S_T3) || (state == S_TW)) && ready && !cyc_write;
        ale       = in_t1;
        rd_n      = !(strobe_ph && !cyc_write);
        wr_n      = !(strobe_ph && cyc_write);
        den_n     = !(strobe_ph || ((state == S_T4) && cyc_write));
        done      = (state == S_T4);
        hlda      = (state == S_HOLD);
        ctl_oe    = (state != S_HOLD);
    end

endmodule

// File: rtl/mbs_path.sv
module mbs_path #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    localparam int STAT_W = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              cap_rd,
    input  logic              in_t1,
    input  logic              data_ph,
    input  logic              in_cyc,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic              req_mem,
    input  logic              req_upper,
    input  logic [STAT_W-1:0] req_status,
    input  logic [DATA_W-1:0] ad_in,
    output logic              cyc_write,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [STAT_W-1:0] ahs_out,
    output logic              bhe_n,
    output logic              mio,
    output logic              dtr
);

    logic [ADDR_W-1:0] cyc_addr;
    logic [DATA_W-1:0] cyc_wdata;
    logic [STAT_W-1:0] cyc_status;
    logic              cyc_mem;
    logic              cyc_upper;

    // Capture the request at acceptance and the read data at strobe end
    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_addr   <= '0;
            cyc_wdata  <= '0;
            cyc_status <= '0;
            cyc_write  <= 1'b0;
            cyc_mem    <= 1'b0;
            cyc_upper  <= 1'b0;
            rd_data    <= '0;
        end else begin
            if (accept) begin
                cyc_addr   <= req_addr;
                cyc_wdata  <= req_wdata;
                cyc_status <= req_status;
                cyc_write  <= req_write;
                cyc_mem    <= req_mem;
                cyc_upper  <= req_upper;
            end
            if (cap_rd) rd_data <= ad_in;
        end
    end

    // Pin multiplexing
    always_comb begin
        ad_out  = in_t1 ? cyc_addr[DATA_W-1:0] : cyc_wdata;
        ad_oe   = in_t1 || (data_ph && cyc_write);
        ahs_out = in_t1 ? cyc_addr[ADDR_W-1:DATA_W] : cyc_status;
        bhe_n   = in_t1 ? !cyc_upper : !data_ph;
        mio     = in_cyc && cyc_mem;
        dtr     = in_cyc && cyc_write;
    end

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    localparam int STAT_W = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic              req_mem,
    input  logic              req_upper,
    input  logic [STAT_W-1:0] req_status,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in,
    output logic [STAT_W-1:0] ahs_out,
    output logic              bhe_n,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              mio,
    output logic              den_n,
    output logic              dtr,
    output logic              ctl_oe,
    input  logic              ready,
    input  logic              hold,
    output logic              hlda
);

    logic accept, cap_rd, in_t1, data_ph, in_cyc, cyc_write;

    mbs_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .hold      (hold),
        .ready     (ready),
        .cyc_write (cyc_write),
        .accept    (accept),
        .cap_rd    (cap_rd),
        .in_t1     (in_t1),
        .data_ph   (data_ph),
        .in_cyc    (in_cyc),
        .ale       (ale),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .den_n     (den_n),
        .done      (done),
        .hlda      (hlda),
        .ctl_oe    (ctl_oe)
    );

    mbs_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .cap_rd     (cap_rd),
        .in_t1      (in_t1),
        .data_ph    (data_ph),
        .in_cyc     (in_cyc),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_write  (req_write),
        .req_mem    (req_mem),
        .req_upper  (req_upper),
        .req_status (req_status),
        .ad_in      (ad_in),
        .cyc_write  (cyc_write),
        .rd_data    (rd_data),
        .ad_out     (ad_out),
        .ad_oe      (ad_oe),
        .ahs_out    (ahs_out),
        .bhe_n      (bhe_n),
        .mio        (mio),
        .dtr        (dtr)
    );

endmodule

// File: rtl/mux_bus_seq_chk.sv
module mux_bus_seq_chk (
    input logic clk,
    input logic rst,
    input logic ready,
    input logic hold,
    input logic done,
    input logic ad_oe,
    input logic ale,
    input logic rd_n,
    input logic wr_n,
    input logic den_n,
    input logic dtr,
    input logic ctl_oe,
    input logic hlda
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (rd_n && wr_n && den_n && !ale && !hlda && !done));

    assert_ale_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);

    assert_ale_drives_R2: assert property (@(posedge clk) disable iff (rst)
        ale |-> (ad_oe && ctl_oe));

    assert_read_float_R4: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> (!ad_oe && !dtr));

    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    assert_write_dir_R6: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> (dtr && ad_oe));

    assert_den_cover_R7: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> !den_n);

    assert_wait_rd_R8: assert property (@(posedge clk) disable iff (rst)
        (!rd_n && !ready) |=> !rd_n);

    assert_wait_wr_R8: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && !ready) |=> !wr_n);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (rd_n && wr_n));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_hold_float_R10: assert property (@(posedge clk) disable iff (rst)
        hlda |-> (!ctl_oe && !ad_oe && !ale));

    assert_hold_midcycle_R10: assert property (@(posedge clk) disable iff (rst)
        (hold && (!rd_n || !wr_n)) |=> !hlda);

endmodule

bind mux_bus_seq mux_bus_seq_chk chk_i (
    .clk    (clk),
    .rst    (rst),
    .ready  (ready),
    .hold   (hold),
    .done   (done),
    .ad_oe  (ad_oe),
    .ale    (ale),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .den_n  (den_n),
    .dtr    (dtr),
    .ctl_oe (ctl_oe),
    .hlda   (hlda)
);

// File: tb/mux_bus_seq_tb_top.sv
module mux_bus_seq_tb_top;

    typedef struct packed {
        logic        wr;
        logic        mem;
        logic        up;
        logic [19:0] addr;
        logic [15:0] wd;
        logic [3:0]  st;
        logic [2:0]  waits;
        logic [15:0] rv;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        {1'b0, 1'b1, 1'b1, 20'hABCDE, 16'h0000, 4'h3, 3'd0, 16'h1234},
        {1'b1, 1'b1, 1'b0, 20'h12345, 16'hBEEF, 4'h5, 3'd0, 16'h0000},
        {1'b0, 1'b0, 1'b1, 20'h003F8, 16'h0000, 4'h9, 3'd2, 16'h55AA},
        {1'b1, 1'b0, 1'b1, 20'h0FFFF, 16'h0001, 4'hF, 3'd3, 16'h0000},
        {1'b0, 1'b1, 1'b0, 20'hFFFFF, 16'h0000, 4'h0, 3'd1, 16'hFFFF},
        {1'b1, 1'b1, 1'b0, 20'h00000, 16'hFFFF, 4'hA, 3'd5, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_write = 1'b0;
    logic        req_mem = 1'b0;
    logic        req_upper = 1'b0;
    logic [3:0]  req_status = '0;
    logic [15:0] ad_in = '0;
    logic        ready = 1'b0;
    logic        hold = 1'b0;
    logic        done, ad_oe, bhe_n, ale, rd_n, wr_n, mio, den_n, dtr, ctl_oe, hlda;
    logic [15:0] rd_data, ad_out;
    logic [3:0]  ahs_out;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    mux_bus_seq dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_write(req_write), .req_mem(req_mem),
        .req_upper(req_upper), .req_status(req_status), .done(done),
        .rd_data(rd_data), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
        .ahs_out(ahs_out), .bhe_n(bhe_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .mio(mio), .den_n(den_n), .dtr(dtr), .ctl_oe(ctl_oe), .ready(ready),
        .hold(hold), .hlda(hlda)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(input vec_t v);
        req_addr = v.addr; req_wdata = v.wd; req_write = v.wr;
        req_mem = v.mem; req_upper = v.up; req_status = v.st; ad_in = v.rv;
    endtask

    // Runs one cycle from IDLE; returns at the negedge after T4
    task automatic run_txn(input vec_t v);
        int n;
        @(negedge clk);
        load(v); req_valid = 1'b1; ready = 1'b0;
        @(negedge clk);
        chk(ale == 1'b1 && ad_oe && ctl_oe, "R2 ale/oe in T1", {ale, ad_oe, ctl_oe}, 3'b111);
        chk(ad_out == v.addr[15:0] && ahs_out == v.addr[19:16], "R2 address",
            {ahs_out, ad_out}, v.addr);
        chk(bhe_n == !v.up, "R2 bhe_n", bhe_n, !v.up);
        chk(mio == v.mem && dtr == v.wr, "R6 mio/dtr T1", {mio, dtr}, {v.mem, v.wr});
        req_valid = 1'b0;
        n = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (done) break;
            n++;
            chk(ahs_out == v.st && bhe_n == 1'b0, "R3 status", {bhe_n, ahs_out}, {1'b0, v.st});
            chk(v.wr ? (!wr_n && rd_n) : (!rd_n && wr_n), "R4 R5 strobe", {rd_n, wr_n}, {v.wr, !v.wr});
            chk(!den_n, "R7 den_n low", den_n, 0);
            chk(mio == v.mem && dtr == v.wr, "R6 mio/dtr", {mio, dtr}, {v.mem, v.wr});
            if (v.wr) chk(ad_oe && ad_out == v.wd, "R5 write data", {ad_oe, ad_out}, {1'b1, v.wd});
            else      chk(!ad_oe, "R4 bus released", ad_oe, 0);
            ready = (n >= v.waits + 2);
        end
        chk(done == 1'b1 && n == v.waits + 2, "R8 strobe length", n, v.waits + 2);
        chk(rd_n && wr_n, "R9 strobes high at done", {rd_n, wr_n}, 2'b11);
        chk(ahs_out == v.st, "R3 status in T4", ahs_out, v.st);
        chk(den_n == !v.wr, "R7 den_n in T4", den_n, !v.wr);
        if (!v.wr) chk(rd_data == v.rv, "R4 read data", rd_data, v.rv);
        else       chk(ad_oe && ad_out == v.wd, "R5 write data T4", ad_out, v.wd);
        ready = 1'b0;
        @(negedge clk);
        chk(!done && rd_n && wr_n && !ale, "R9 done single", {done, ale}, 0);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        vec_t hv;
        // R1: reset state with a pending request
        load(VEC[0]); req_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk(rd_n && wr_n && den_n && !ale && !hlda && !done, "R1 reset idle",
            {rd_n, wr_n, den_n, ale, hlda, done}, 6'b111000);
        req_valid = 1'b0; rst = 1'b0;
        @(negedge clk);

        // Vector table
        for (int i = 0; i < NV; i++) run_txn(VEC[i]);

        // R10/R11: hold raised mid-cycle with a request kept pending
        hv = VEC[2];
        @(negedge clk);
        load(hv); req_valid = 1'b1; ready = 1'b1;   // ready high in T2 too (R8)
        @(negedge clk);                             // T1
        hold = 1'b1;
        @(negedge clk);                             // T2
        chk(!hlda, "R10 no grant in T2", hlda, 0);
        @(negedge clk);                             // T3
        @(negedge clk);                             // T4
        chk(done && !hlda, "R8 ready ignored in T2 / R10", {done, hlda}, 2'b10);
        chk(rd_data == hv.rv, "R4 read data (hold case)", rd_data, hv.rv);
        @(negedge clk);                             // IDLE
        chk(!hlda && !ale, "R10 idle before grant", {hlda, ale}, 0);
        @(negedge clk);                             // HOLD
        chk(hlda && !ctl_oe && !ad_oe && !ale, "R10 grant over request",
            {hlda, ctl_oe, ad_oe, ale}, 4'b1000);
        @(negedge clk);
        chk(hlda && !ale, "R10 hold kept", {hlda, ale}, 2'b10);
        hold = 1'b0;
        @(negedge clk);                             // IDLE
        chk(!hlda && ctl_oe && !ale, "R11 release", {hlda, ctl_oe, ale}, 3'b010);
        @(negedge clk);                             // T1
        chk(ale && ad_out == hv.addr[15:0], "R11 resume", {ale, ad_out}, {1'b1, hv.addr[15:0]});
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(!done && rd_n && wr_n, "R9 cycle over", done, 0);

        // R1: reset during a wait state with request held
        hv = VEC[5];
        @(negedge clk);
        load(hv); req_valid = 1'b1; ready = 1'b0;
        repeat (4) @(negedge clk);                  // T1,T2,T3,TW
        chk(!wr_n, "R8 waiting", wr_n, 0);
        rst = 1'b1;
        @(negedge clk);
        chk(rd_n && wr_n && den_n && !ale && !done, "R1 reset mid-cycle",
            {rd_n, wr_n, den_n, ale, done}, 5'b11100);
        @(negedge clk);
        chk(!ale, "R1 no start in reset", ale, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(ale && ad_out == hv.addr[15:0], "R1 start after reset", {ale, ad_out}, {1'b1, hv.addr[15:0]});
        req_valid = 1'b0; ready = 1'b1;
        repeat (4) @(negedge clk);
        ready = 1'b0;

        // R10: hold in plain idle
        @(negedge clk);
        hold = 1'b1;
        @(negedge clk);
        chk(hlda && !ctl_oe, "R10 idle grant", {hlda, ctl_oe}, 2'b10);
        hold = 1'b0;
        @(negedge clk);
        chk(!hlda && ctl_oe, "R11 idle release", {hlda, ctl_oe}, 2'b01);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule